// File: doc/BRIEF.md
# Self-Repairing Triple-Redundant Enable Register

This block holds a register of parameterized width as three redundant copies. Each copy is a flip-flop with a clock enable, an asynchronous clear and an asynchronous preset. Every copy is loaded from one next value. When the functional enable is high, that value is the input data. When the enable is low, it is the bitwise majority of the three copies. The output is the majority of the three copies, so a single corrupted copy never reaches the consumer.

Voting the input of a flip-flop does not repair what the flip-flop already stores while its enable is low. To fix this, each copy has a per-bit minority detector that flags the bits where this copy disagrees with both other copies. The detector output is ORed into the clock enable of exactly those bits. On the next clock edge those bits reload the majority value, even with the functional enable low. This closes the window before a second upset can hit another copy of the same bit.

A per-copy, per-bit injection port lets a test invert stored bits. A mismatch flag reports any cycle in which some bit of some copy disagrees with the majority.

Top module: `tmr_enable_reg`

## Requirements
- R1: While `rst_ni` is low, all copies clear asynchronously: `q_o` is all zeros and `mismatch_o` is 0. Clear has priority over preset.
- R2: While `rst_ni` is high and `pre_i` is high, all copies preset asynchronously and `q_o` is all ones. Preset has priority over clocked loads and injection.
- R3: On a clock edge with `en_i` high, `q_o` takes the value of `d_i` after that edge.
- R4: On a clock edge with `en_i` low and no injection, `q_o` keeps its value whatever `d_i` is.
- R5: Setting bit `b` of `flip_i[k]` inverts bit `b` of copy `k` at that clock edge, in place of its load. When at most one copy of each bit is hit, `q_o` is the same as it would be with no injection.
- R6: `mismatch_o` is high in the cycle after an edge that injected an upset into any bit of any copy.
- R7: With `en_i` low and no new injection, a disagreeing bit reloads on the next edge, and `mismatch_o` returns to 0 after that edge.
- R8: During a repair with `en_i` low, the disagreeing bit reloads the majority value, not `d_i`. With `d_i` equal to the inverse of `q_o`, `mismatch_o` still clears.
- R9: Upsets that hit all three copies of one bit in turn, with a repair edge between them, leave `q_o` unchanged.
- R10: Upsets in different bits of different copies on the same edge leave `q_o` unchanged and are all repaired on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous clear of all copies |
| pre_i | input | 1 | Active-high asynchronous preset of all copies |
| en_i | input | 1 | Functional load enable |
| d_i | input | WIDTH | Data loaded when `en_i` is high |
| flip_i | input | 3 x WIDTH | Per-copy, per-bit upset injection, applied at the clock edge |
| q_o | output | WIDTH | Majority-voted register value |
| mismatch_o | output | 1 | Some bit of some copy differs from the majority |

## Verification
Clear and preset act at once, so the bench checks them one time unit after the control changes. A load, hold or injection shows up on `q_o` and `mismatch_o` right after the edge that samples it, because both outputs are combinational over the copies. A repair shows up one edge later. The bench drives inputs at the falling edge and samples at the next falling edge. Every expected value therefore belongs to exactly one rising edge: injection is checked one edge after it is applied, and repair one edge after that.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCOPY = 3;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] maj_o
);
  assign maj_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/tmr_minority.sv
module tmr_minority #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] own_i,
  input  logic [WIDTH-1:0] oth0_i,
  input  logic [WIDTH-1:0] oth1_i,
  output logic [WIDTH-1:0] odd_o
);
  // bit disagrees with both neighbours
  assign odd_o = (own_i ^ oth0_i) & (own_i ^ oth1_i);
endmodule

// File: rtl/tmr_copy.sv
module tmr_copy #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic [WIDTH-1:0] ce_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] flip_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge pre_i) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (pre_i) begin
      q_o <= '1;
    end else begin
      for (int b = 0; b < WIDTH; b++) begin
        if (flip_i[b])    q_o[b] <= ~q_o[b];
        else if (ce_i[b]) q_o[b] <= d_i[b];
      end
    end
  end
endmodule

// File: rtl/tmr_enable_reg.sv
module tmr_enable_reg
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pre_i,
  input  logic                        en_i,
  input  logic [WIDTH-1:0]            d_i,
  input  logic [NCOPY-1:0][WIDTH-1:0] flip_i,
  output logic [WIDTH-1:0]            q_o,
  output logic                        mismatch_o
);
  logic [NCOPY-1:0][WIDTH-1:0] cp_q;
  logic [NCOPY-1:0][WIDTH-1:0] cp_odd;
  logic [NCOPY-1:0][WIDTH-1:0] cp_ce;
  logic [WIDTH-1:0]            maj;
  logic [WIDTH-1:0]            nxt;
  logic [WIDTH-1:0]            odd_any;

  tmr_vote #(.WIDTH(WIDTH)) i_vote (
    .a_i(cp_q[0]), .b_i(cp_q[1]), .c_i(cp_q[2]), .maj_o(maj)
  );

  // shared voted next value
  assign nxt = en_i ? d_i : maj;

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    localparam int unsigned K1 = (k + 1) % NCOPY;
    localparam int unsigned K2 = (k + 2) % NCOPY;

    tmr_minority #(.WIDTH(WIDTH)) i_min (
      .own_i (cp_q[k]),
      .oth0_i(cp_q[K1]),
      .oth1_i(cp_q[K2]),
      .odd_o (cp_odd[k])
    );

    // minority forces reload of the odd bits
    assign cp_ce[k] = {WIDTH{en_i}} | cp_odd[k];

    tmr_copy #(.WIDTH(WIDTH)) i_copy (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pre_i (pre_i),
      .ce_i  (cp_ce[k]),
      .d_i   (nxt),
      .flip_i(flip_i[k]),
      .q_o   (cp_q[k])
    );
  end

  assign odd_any    = cp_odd[0] | cp_odd[1] | cp_odd[2];
  assign mismatch_o = |odd_any;
  assign q_o        = maj;

  logic [WIDTH-1:0] multi_hit;
  assign multi_hit = (flip_i[0] & flip_i[1]) | (flip_i[0] & flip_i[2]) | (flip_i[1] & flip_i[2]);

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || pre_i)
    $past(rst_ni) && !$past(pre_i) && $past(en_i) && !$past(mismatch_o) && ($past(multi_hit) == '0)
    |-> q_o == $past(d_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || pre_i)
    $past(rst_ni) && !$past(pre_i) && !$past(en_i) && ($past(flip_i) == '0)
    |-> q_o == $past(q_o));

  // R7
  repair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || pre_i)
    $past(rst_ni) && !$past(pre_i) && $past(mismatch_o) && ($past(flip_i) == '0)
    |-> !mismatch_o);

  // R2
  preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (q_o == '1) && !mismatch_o);

  // R1
  clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0) && !mismatch_o);
endmodule

// File: tb/test_tmr_enable_reg.sv
module test_tmr_enable_reg;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni, pre_i, en_i;
  logic [W-1:0]     d_i;
  logic [2:0][W-1:0] flip_i;
  logic [W-1:0]     q_o;
  logic             mismatch_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tmr_enable_reg #(.WIDTH(W)) i_tmr_enable_reg (
    .clk_i, .rst_ni, .pre_i, .en_i, .d_i, .flip_i, .q_o, .mismatch_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_q(string req, logic [W-1:0] exp);
    checks++;
    if (q_o !== exp) begin
      errors++;
      $display("FAIL %s q_o actual %h expected %h", req, q_o, exp);
    end
  endtask

  task automatic chk_m(string req, logic exp);
    checks++;
    if (mismatch_o !== exp) begin
      errors++;
      $display("FAIL %s mismatch_o actual %b expected %b", req, mismatch_o, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 0; pre_i = 0; en_i = 0; d_i = '0; flip_i = '0;
    step(); step();
    chk_q("R1", '0); chk_m("R1", 0);
    rst_ni = 1; step();
    chk_q("R1", '0);
  endtask

  task automatic t_preset();
    pre_i = 1; #1;
    chk_q("R2", '1); chk_m("R2", 0);
    en_i = 1; d_i = 8'h00; step();
    chk_q("R2", '1);
    rst_ni = 0; #1;
    chk_q("R1", '0);
    pre_i = 0; en_i = 0; #1; rst_ni = 1;
    step();
    chk_q("R1", '0);
  endtask

  task automatic t_load();
    en_i = 1; d_i = 8'hA5; step();
    chk_q("R3", 8'hA5);
    d_i = 8'h3C; step();
    chk_q("R3", 8'h3C);
    en_i = 0;
  endtask

  task automatic t_hold();
    en_i = 0; d_i = 8'hFF;
    for (int i = 0; i < 3; i++) step();
    chk_q("R4", 8'h3C); chk_m("R4", 0);
  endtask

  task automatic t_upset();
    logic [W-1:0] v;
    v = q_o;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < W; b += 3) begin
        en_i = 0; d_i = ~v;
        flip_i = '0; flip_i[k][b] = 1'b1;
        step();
        flip_i = '0;
        chk_q("R5", v); chk_m("R6", 1);
        step();
        chk_m("R8", 0); chk_q("R7", v);
      end
    end
  endtask

  task automatic t_seq();
    logic [W-1:0] v;
    v = q_o;
    for (int k = 0; k < 3; k++) begin
      flip_i = '0; flip_i[k][3] = 1'b1;
      step();
      flip_i = '0;
      chk_q("R9", v);
      step();
      chk_m("R9", 0);
    end
    chk_q("R9", v);
  endtask

  task automatic t_multi();
    logic [W-1:0] v;
    v = q_o;
    flip_i = '0;
    flip_i[0][0] = 1'b1; flip_i[1][1] = 1'b1; flip_i[2][7] = 1'b1;
    step();
    flip_i = '0;
    chk_q("R10", v); chk_m("R10", 1);
    step();
    chk_m("R10", 0); chk_q("R10", v);
  endtask

  task automatic t_load_upset();
    en_i = 1; d_i = 8'h5A; flip_i = '0; flip_i[1] = '1;
    step();
    flip_i = '0; en_i = 0;
    chk_q("R5", 8'h5A); chk_m("R6", 1);
    step();
    chk_m("R7", 0); chk_q("R7", 8'h5A);
  endtask

  initial begin
    t_reset();
    t_preset();
    t_load();
    t_hold();
    t_upset();
    t_seq();
    t_multi();
    t_load_upset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule